// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block holds the pending state of two interrupt sources in front of a CPU interrupt controller. Source 0 is an external pin that software places either in edge mode, where a rising edge sets a sticky request flag, or in level mode, where the pending output simply follows the synchronized pin. Source 1 is a serial-receive request whose flag can be made immune to software clear writes by a level-enable bit, so that only draining the receive buffer removes it. Software clears flags by writing a byte code to a clear port. The code is decoded into a one-hot clear pulse. Reset restores edge mode and disables the receive level enable.

A small three-state machine carries the CPU acknowledge/vector-read handshake. In state VS_IDLE an `ack` with a source number moves it to VS_WAIT (transition T_ACK); other inputs leave it in VS_IDLE. In VS_WAIT a `vec_rd` moves it to VS_DRIVE (transition T_READ) and registers the vector: the source's own offset if its pending bit is still set in that cycle, otherwise the default offset 0x0004. Further `ack` pulses in VS_WAIT are ignored. VS_DRIVE raises `vec_valid` for exactly one cycle and always returns to VS_IDLE (transition T_DONE).

Top module: `irq_flag_latch`

## Requirements
- R1: In edge mode (`ext_level_mode`=0) a 0→1 change of `ext_pin` sets `pend[0]`. It is seen at the third rising clock edge after the pin change and stays set until cleared.
- R2: In level mode (`ext_level_mode`=1) `pend[0]` equals the pin level delayed by the two synchronizer stages. This includes dropping to 0 when the pin falls, with no clear write.
- R3: Changing `ext_level_mode` from 0 to 1 clears the stored external flag, so a flag set in edge mode is gone when the source returns to edge mode.
- R4: Changing `ext_level_mode` from 1 to 0 while the pin is high leaves `pend[0]` set after the pin falls, until a clear write removes it.
- R5: A `clr_wr` with `clr_data`=0x0A clears `pend[0]` (edge mode) and with 0x0B clears `pend[1]` (receive level enable 0). Every other byte value leaves both flags unchanged.
- R6: With `rx_level_en`=1, clear writes have no effect on `pend[1]`, while a `rxbuf_rd` pulse clears it.
- R7: `vec_valid` is high for exactly one cycle, one edge after a `vec_rd` that follows an `ack`. `vec_out` is then 0x0028 for source 0 or 0x0050 for source 1 (`ack_src`=0/1) if that source's pending bit was 1 in the `vec_rd` cycle, and otherwise 0x0004.
- R8: After reset `pend`=0, `vec_valid`=0, `vec_out`=0x0004, the external source is in edge mode and the receive level enable is off.
- R9: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: A one-cycle `rx_req` pulse sets `pend[1]` at the next edge. With the level enable off, a `rxbuf_rd` pulse also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Raw external interrupt pin, asynchronous |
| ext_level_mode | input | 1 | External source mode: 0 edge, 1 level |
| rx_req | input | 1 | Serial-receive request, synchronous |
| rx_level_en | input | 1 | Receive flag level enable (blocks clear writes) |
| clr_wr | input | 1 | Clear-code write strobe |
| clr_data | input | 8 | Clear code byte |
| rxbuf_rd | input | 1 | Receive-buffer read strobe |
| ack | input | 1 | CPU accepts an interrupt |
| ack_src | input | 1 | Accepted source: 0 external, 1 receive |
| vec_rd | input | 1 | CPU vector read strobe |
| pend | output | 2 | Pending bits: [0] external, [1] receive |
| vec_out | output | 16 | Vector offset returned to the CPU |
| vec_valid | output | 1 | One-cycle vector-valid pulse |

## Verification
The bench sweeps all 256 clear codes with both flags set, once with the receive level enable off and once with it on. A decoder that matched extra codes, or a receive flag that honoured writes in level mode, would drop a flag that should stay. It drives an edge and a clear into the same cycle, where a design giving the clear priority would lose the request. It also takes the external source through both mode changes: a design that auto-clears in the wrong direction would either keep a stale flag after level mode or lose the flag inherited from level mode. The vector handshake is run for each source and each combination of flag kept or cleared between acknowledge and read. A design that latched the vector at acknowledge time would return the source vector where the default is due.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    localparam int NUM_SRC = 2;
    localparam int SRC_EXT = 0;
    localparam int SRC_RX  = 1;

    typedef enum logic [1:0] {
        VS_IDLE  = 2'd0,
        VS_WAIT  = 2'd1,
        VS_DRIVE = 2'd2
    } vec_state_e;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async[b];
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async[b]};
            end
        end

        assign d_sync[b] = chain_q[LAST];
    end

endmodule

// File: rtl/irq_clr_decode.sv
module irq_clr_decode #(
    parameter int                        NSRC   = 2,
    parameter int                        CODE_W = 8,
    parameter logic [NSRC*CODE_W-1:0]    CODES  = {8'h0B, 8'h0A}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] data,
    output logic [NSRC-1:0]   clr_pulse
);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam logic [CODE_W-1:0] MY_CODE = CODES[s*CODE_W +: CODE_W];
        assign clr_pulse[s] = wr && (data == MY_CODE);
    end

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_pulse)); // R5

    AST_CLR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |-> (clr_pulse == '0)); // R5

endmodule

// File: rtl/irq_ext_flag.sv
module irq_ext_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic level_in,
    input  logic clr,
    output logic pend
);

    logic mode_q;
    logic prev_q;
    logic flag_q;
    logic rise;
    logic to_level;

    assign rise     = pin_s && !prev_q;
    assign to_level = !mode_q && level_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            mode_q <= level_in;
            prev_q <= pin_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (to_level) begin
            flag_q <= 1'b0;
        end else if (mode_q) begin
            flag_q <= pin_s;
        end else begin
            flag_q <= rise || (flag_q && !clr);
        end
    end

    assign pend = mode_q ? pin_s : flag_q;

    AST_EXT_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !level_in && rise) |=> flag_q); // R9

    AST_EXT_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        to_level |=> !flag_q); // R3

    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !level_in && flag_q && !clr) |=> flag_q); // R1

endmodule

// File: rtl/irq_rx_flag.sv
module irq_rx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic level_en,
    input  logic clr,
    input  logic buf_rd,
    output logic pend
);

    logic lvl_q;
    logic flag_q;
    logic clr_ok;
    logic kill;

    assign clr_ok = clr && !lvl_q;
    assign kill   = clr_ok || buf_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            lvl_q  <= level_en;
            flag_q <= req || (flag_q && !kill);
        end
    end

    assign pend = flag_q;

    AST_RX_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q && flag_q && !buf_rd) |=> flag_q); // R6

    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> flag_q); // R9

    AST_RX_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !req) |=> !flag_q); // R10

endmodule

// File: rtl/irq_vec_fsm.sv
module irq_vec_fsm
    import irq_latch_pkg::*;
#(
    parameter int              NSRC        = 2,
    parameter int              VEC_W       = 16,
    parameter logic [VEC_W-1:0] VEC_DEFAULT = 16'h0004,
    parameter logic [VEC_W-1:0] VEC_EXT     = 16'h0028,
    parameter logic [VEC_W-1:0] VEC_RX      = 16'h0050
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend,
    input  logic             ack,
    input  logic             ack_src,
    input  logic             vec_rd,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);

    vec_state_e       state_q, state_d;
    logic             src_q;
    logic [VEC_W-1:0] vec_q;
    logic [VEC_W-1:0] src_vec;
    logic             src_live;

    assign src_live = src_q ? pend[SRC_RX] : pend[SRC_EXT];
    assign src_vec  = src_q ? VEC_RX : VEC_EXT;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_IDLE:  if (ack)    state_d = VS_WAIT;   // T_ACK
            VS_WAIT:  if (vec_rd) state_d = VS_DRIVE;  // T_READ
            VS_DRIVE:             state_d = VS_IDLE;   // T_DONE
            default:              state_d = VS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            vec_q <= VEC_DEFAULT;
        end else begin
            if (state_q == VS_IDLE && ack) src_q <= ack_src;
            if (state_q == VS_WAIT && vec_rd) vec_q <= src_live ? src_vec : VEC_DEFAULT;
        end
    end

    always_comb begin
        vec_valid = (state_q == VS_DRIVE);
        vec_out   = vec_q;
    end

    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid); // R7

    AST_VEC_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VS_WAIT && vec_rd && !src_live) |=> (vec_valid && vec_out == VEC_DEFAULT)); // R7

    AST_VEC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(vec_rd)); // R7

endmodule

// File: rtl/irq_flag_latch.sv
module irq_flag_latch
    import irq_latch_pkg::*;
#(
    parameter int                 SYNC_STAGES  = 2,
    parameter int                 CODE_W       = 8,
    parameter int                 VEC_W        = 16,
    parameter logic [CODE_W-1:0]  CLR_CODE_EXT = 8'h0A,
    parameter logic [CODE_W-1:0]  CLR_CODE_RX  = 8'h0B,
    parameter logic [VEC_W-1:0]   VEC_DEFAULT  = 16'h0004,
    parameter logic [VEC_W-1:0]   VEC_EXT      = 16'h0028,
    parameter logic [VEC_W-1:0]   VEC_RX       = 16'h0050
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              ext_level_mode,
    input  logic              rx_req,
    input  logic              rx_level_en,
    input  logic              clr_wr,
    input  logic [CODE_W-1:0] clr_data,
    input  logic              rxbuf_rd,
    input  logic              ack,
    input  logic              ack_src,
    input  logic              vec_rd,
    output logic [NUM_SRC-1:0] pend,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid
);

    localparam logic [NUM_SRC*CODE_W-1:0] CODE_TABLE = {CLR_CODE_RX, CLR_CODE_EXT};

    logic               pin_s;
    logic [NUM_SRC-1:0] clr_pulse;
    logic               ext_pend;
    logic               rx_pend;

    irq_pin_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_pin),
        .d_sync  (pin_s)
    );

    irq_clr_decode #(.NSRC(NUM_SRC), .CODE_W(CODE_W), .CODES(CODE_TABLE)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (clr_wr),
        .data      (clr_data),
        .clr_pulse (clr_pulse)
    );

    irq_ext_flag u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .level_in (ext_level_mode),
        .clr      (clr_pulse[SRC_EXT]),
        .pend     (ext_pend)
    );

    irq_rx_flag u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rx_req),
        .level_en (rx_level_en),
        .clr      (clr_pulse[SRC_RX]),
        .buf_rd   (rxbuf_rd),
        .pend     (rx_pend)
    );

    assign pend[SRC_EXT] = ext_pend;
    assign pend[SRC_RX]  = rx_pend;

    irq_vec_fsm #(
        .NSRC(NUM_SRC), .VEC_W(VEC_W), .VEC_DEFAULT(VEC_DEFAULT),
        .VEC_EXT(VEC_EXT), .VEC_RX(VEC_RX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .ack       (ack),
        .ack_src   (ack_src),
        .vec_rd    (vec_rd),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend == '0)); // R8

endmodule

// File: tb/irq_flag_latch_test.sv
`timescale 1ns/1ps
module irq_flag_latch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0;
    logic        ext_level_mode = 1'b0;
    logic        rx_req = 1'b0;
    logic        rx_level_en = 1'b0;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_data = 8'h00;
    logic        rxbuf_rd = 1'b0;
    logic        ack = 1'b0;
    logic        ack_src = 1'b0;
    logic        vec_rd = 1'b0;
    logic [1:0]  pend;
    logic [15:0] vec_out;
    logic        vec_valid;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_flag_latch uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_level_mode(ext_level_mode),
        .rx_req(rx_req), .rx_level_en(rx_level_en), .clr_wr(clr_wr), .clr_data(clr_data),
        .rxbuf_rd(rxbuf_rd), .ack(ack), .ack_src(ack_src), .vec_rd(vec_rd),
        .pend(pend), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ext_pulse();
        ext_pin = 1'b1; tick(4);
        ext_pin = 1'b0; tick(4);
    endtask

    task automatic rx_pulse();
        rx_req = 1'b1; tick(1);
        rx_req = 1'b0;
    endtask

    task automatic write_clr(input logic [7:0] code);
        clr_wr = 1'b1; clr_data = code; tick(1);
        clr_wr = 1'b0; clr_data = 8'h00;
    endtask

    task automatic handshake(input logic src, input bit drop, input logic [15:0] exp, input string req);
        ack = 1'b1; ack_src = src; tick(1);
        ack = 1'b0;
        if (drop) begin
            if (src) rxbuf_rd = 1'b1; else begin clr_wr = 1'b1; clr_data = 8'h0A; end
            tick(1);
            rxbuf_rd = 1'b0; clr_wr = 1'b0; clr_data = 8'h00;
        end
        tick(2);
        check({req, " no early vec_valid"}, {31'd0, vec_valid}, 32'd0);
        vec_rd = 1'b1; tick(1);
        vec_rd = 1'b0;
        check({req, " vec_valid"}, {31'd0, vec_valid}, 32'd1);
        check({req, " vec_out"}, {16'd0, vec_out}, {16'd0, exp});
        tick(1);
        check({req, " vec_valid one cycle"}, {31'd0, vec_valid}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        check("R8 pend reset", {30'd0, pend}, 32'd0);
        check("R8 vec_valid reset", {31'd0, vec_valid}, 32'd0);
        check("R8 vec_out reset", {16'd0, vec_out}, 32'h0004);
        rst_n = 1'b1;
        tick(2);
        // R8: reset leaves edge mode, so a held-high pin must stay pending after falling
        ext_pulse();
        check("R8 edge mode after reset", {31'd0, pend[0]}, 32'd1);
        write_clr(8'h0A);

        // R1: exact latency of edge set, three edges after the pin change
        ext_pin = 1'b1;
        tick(2);
        check("R1 not yet set after two edges", {31'd0, pend[0]}, 32'd0);
        tick(1);
        check("R1 set after third edge", {31'd0, pend[0]}, 32'd1);
        ext_pin = 1'b0; tick(6);
        check("R1 sticky after pin low", {31'd0, pend[0]}, 32'd1);
        write_clr(8'h0A);
        check("R1 cleared by code", {31'd0, pend[0]}, 32'd0);

        // R9: edge set and clear write in the same cycle
        ext_pin = 1'b1; tick(2);
        clr_wr = 1'b1; clr_data = 8'h0A; tick(1);
        clr_wr = 1'b0;
        check("R9 ext set wins", {31'd0, pend[0]}, 32'd1);
        ext_pin = 1'b0; tick(3);
        write_clr(8'h0A);
        // R9: rx set with rxbuf read in the same cycle
        rx_req = 1'b1; rxbuf_rd = 1'b1; tick(1);
        rx_req = 1'b0; rxbuf_rd = 1'b0;
        check("R9 rx set wins", {31'd0, pend[1]}, 32'd1);
        // R10: read strobe clears with level enable off
        rxbuf_rd = 1'b1; tick(1); rxbuf_rd = 1'b0;
        check("R10 rxbuf_rd clears", {31'd0, pend[1]}, 32'd0);
        rx_pulse();
        check("R10 rx_req sets", {31'd0, pend[1]}, 32'd1);
        rxbuf_rd = 1'b1; tick(1); rxbuf_rd = 1'b0;

        // R5: sweep all codes, level enable off
        for (int c = 0; c < 256; c++) begin
            ext_pulse(); rx_pulse();
            write_clr(c[7:0]);
            check("R5 ext after code", {31'd0, pend[0]}, {31'd0, (c != 8'h0A)});
            check("R5 rx after code", {31'd0, pend[1]}, {31'd0, (c != 8'h0B)});
            write_clr(8'h0A); write_clr(8'h0B);
        end

        // R6: sweep all codes, level enable on
        rx_level_en = 1'b1; tick(1);
        for (int c = 0; c < 256; c++) begin
            rx_pulse();
            write_clr(c[7:0]);
            check("R6 rx kept by write", {31'd0, pend[1]}, 32'd1);
            rxbuf_rd = 1'b1; tick(1); rxbuf_rd = 1'b0;
            check("R6 rx cleared by read", {31'd0, pend[1]}, 32'd0);
        end
        rx_level_en = 1'b0; tick(1);

        // R2: level mode follows pin, two edges latency
        ext_level_mode = 1'b1; tick(2);
        ext_pin = 1'b1; tick(1);
        check("R2 not yet after one edge", {31'd0, pend[0]}, 32'd0);
        tick(1);
        check("R2 follows pin high", {31'd0, pend[0]}, 32'd1);
        ext_pin = 1'b0; tick(2);
        check("R2 follows pin low", {31'd0, pend[0]}, 32'd0);

        // R3: flag set in edge mode is cleared by switching to level mode
        ext_level_mode = 1'b0; tick(2);
        ext_pulse();
        check("R3 flag set in edge", {31'd0, pend[0]}, 32'd1);
        ext_level_mode = 1'b1; tick(2);
        check("R3 level shows pin", {31'd0, pend[0]}, 32'd0);
        ext_level_mode = 1'b0; tick(2);
        check("R3 flag gone after return", {31'd0, pend[0]}, 32'd0);

        // R4: level to edge while pin high keeps the flag
        ext_level_mode = 1'b1; tick(1);
        ext_pin = 1'b1; tick(3);
        ext_level_mode = 1'b0; tick(2);
        ext_pin = 1'b0; tick(4);
        check("R4 flag kept after switch", {31'd0, pend[0]}, 32'd1);
        write_clr(8'h0A);
        check("R4 cleared by code", {31'd0, pend[0]}, 32'd0);

        // R7: vector handshake for each source, flag kept or dropped
        for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 2; d++) begin
                if (s == 0) ext_pulse(); else rx_pulse();
                tick(1);
                handshake(s[0], d[0], (d != 0) ? 16'h0004 : ((s != 0) ? 16'h0050 : 16'h0028), "R7");
                write_clr(8'h0A);
                rxbuf_rd = 1'b1; tick(1); rxbuf_rd = 1'b0;
            end
        end
        // R7: acknowledge with nothing pending returns the default vector
        handshake(1'b0, 1'b0, 16'h0004, "R7 idle source");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule